// File: doc/BRIEF.md
# Receive Byte Staging Path with Non-Destructive Read

This block sits between the bit-level receiver of a two-wire serial controller and the software-visible receive data register. It has two one-byte holding slots in series. The first is a shift stage that takes each completed byte from the bit receiver through a valid/ready handshake. The second is a receive buffer that software reads.

A byte moves forward from the shift stage only when the buffer is empty. While a byte waits in the shift stage, the block withholds ready, so no byte from the bit receiver is ever dropped.

Software has two read strobes:
- A pop read returns the buffered byte and frees the slot.
- A peek read returns the same byte and leaves the slot untouched.

The block keeps a data-valid status bit, a sticky data-valid interrupt flag and a sticky underflow interrupt flag. Both interrupt flags are cleared by a write-one-to-clear strobe. When no byte is held or no read is strobed, the read data is forced to zero.

Top module: `rxq_rx_path`

## Requirements
- R1: After synchronous reset, `byte_ready_o` is 1, and `data_valid_o`, `dv_irq_o` and `uf_irq_o` are 0.
- R2: `byte_ready_o` is low exactly while the shift stage holds a byte. It falls the cycle after a handshake (`byte_valid_i` and `byte_ready_o` both high). It rises again the cycle after that byte moves into the buffer.
- R3: A byte in the shift stage moves into the buffer on the next clock edge if the buffer is empty. From that edge on, `data_valid_o` is 1. A handshake at edge N therefore gives `data_valid_o` = 1 after edge N+1.
- R4: `dv_irq_o` is set on the same edge that the buffer gains a byte. It is cleared by a pop read of a held byte, or by `flag_clr_i[0]`. A fill on the same edge wins over that clear.
- R5: A pop read while `data_valid_o` is 0 sets `uf_irq_o` from the next cycle on, and returns 0 on `rd_data_o`. A pop read while `data_valid_o` is 1 clears `data_valid_o` on the next cycle.
- R6: A peek read (`peek_i` high, `pop_i` low) shows the buffered byte on `rd_data_o`. It changes neither `data_valid_o` nor `uf_irq_o`.
- R7: A pop read while a byte waits in the shift stage gives `data_valid_o` = 0 for exactly one cycle. The waiting byte then enters the buffer, and `data_valid_o` and `dv_irq_o` are 1 again.
- R8: `uf_irq_o` stays set until `flag_clr_i[1]` is pulsed. An underflow on the same cycle as that clear leaves the flag set.
- R9: `rd_data_o` is 0 whenever the buffer is empty or neither `pop_i` nor `peek_i` is high.
- R10: Bytes leave through pop reads in the order in which they were accepted from the bit receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| byte_valid_i | input | 1 | Bit receiver offers a completed byte |
| byte_data_i | input | DATA_W | Completed byte from the bit receiver |
| byte_ready_o | output | 1 | Shift stage can take a byte |
| pop_i | input | 1 | Destructive read strobe |
| peek_i | input | 1 | Non-destructive read strobe |
| rd_data_o | output | DATA_W | Read data; zero when the buffer is empty or no read is strobed |
| data_valid_o | output | 1 | Buffer holds a byte |
| dv_irq_o | output | 1 | Data-valid interrupt flag |
| uf_irq_o | output | 1 | Underflow interrupt flag |
| flag_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 data-valid flag, bit 1 underflow flag |

## Verification
Two functions can land on the same edge: a pop read of an empty buffer, and the move of a waiting shift-stage byte into that buffer. In that cycle the read must return zero and raise underflow, and the byte must still arrive with data-valid set on the next cycle.

A directed case provokes this by popping exactly one cycle after a handshake. The random phase reaches the same collision, and the related set-versus-clear collisions of both flags, many more times. It judges every cycle against a reference model in the bench, which is built from the requirements, and against a queue that records the order of accepted bytes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Occupancy of a one-byte holding slot
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_e;

    // Bit positions inside the write-one-to-clear strobe vector
    localparam int CLR_DV_BIT = 0;
    localparam int CLR_UF_BIT = 1;
    localparam int CLR_W      = 2;

    // Sticky flag update: a set on the same edge wins over a clear
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/rxq_slot.sv
module rxq_slot
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              drain_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              held_o,
    output logic [DATA_W-1:0] data_o
);

    slot_e             state_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SLOT_EMPTY;
            data_q  <= '0;
        end else begin
            if (drain_i) begin
                state_q <= SLOT_EMPTY;
            end
            if (load_i) begin
                state_q <= SLOT_HELD;
                data_q  <= data_i;
            end
        end
    end

    assign held_o = (state_q == SLOT_HELD);
    assign data_o = data_q;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fill_i,
    input  logic              pop_i,
    input  logic              buf_held_i,
    input  logic [CLR_W-1:0]  clr_i,
    output logic              dv_irq_o,
    output logic              uf_irq_o
);

    logic dv_q;
    logic uf_q;
    logic dv_clr;
    logic uf_set;

    // A destructive read of a held byte retires the data-valid flag
    assign dv_clr = clr_i[CLR_DV_BIT] | (pop_i & buf_held_i);
    // A destructive read with nothing held is an underflow
    assign uf_set = pop_i & ~buf_held_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dv_q <= 1'b0;
            uf_q <= 1'b0;
        end else begin
            dv_q <= flag_next(dv_q, fill_i, dv_clr);
            uf_q <= flag_next(uf_q, uf_set, clr_i[CLR_UF_BIT]);
        end
    end

    assign dv_irq_o = dv_q;
    assign uf_irq_o = uf_q;

endmodule

// File: rtl/rxq_read_port.sv
module rxq_read_port #(
    parameter int DATA_W     = 8,
    parameter bit EMPTY_ZERO = 1'b1
) (
    input  logic              held_i,
    input  logic              pop_i,
    input  logic              peek_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic strobe;
    assign strobe = pop_i | peek_i;

    generate
        if (EMPTY_ZERO) begin : g_zero_fill
            // Deterministic value when the read has no defined content
            assign rd_data_o = (held_i && strobe) ? data_i : '0;
        end else begin : g_pass
            assign rd_data_o = strobe ? data_i : '0;
        end
    endgenerate

endmodule

// File: rtl/rxq_rx_path.sv
module rxq_rx_path
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    output logic              byte_ready_o,
    input  logic              pop_i,
    input  logic              peek_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              data_valid_o,
    output logic              dv_irq_o,
    output logic              uf_irq_o,
    input  logic [CLR_W-1:0]  flag_clr_i
);

    logic              sh_held;
    logic [DATA_W-1:0] sh_data;
    logic              bf_held;
    logic [DATA_W-1:0] bf_data;
    logic              accept;
    logic              advance;
    logic              bf_drain;

    // Shift stage takes a byte only when empty; that is the backpressure
    assign accept   = byte_valid_i & ~sh_held;
    // Forward move only into an empty buffer
    assign advance  = sh_held & ~bf_held;
    assign bf_drain = pop_i & bf_held;

    rxq_slot #(.DATA_W(DATA_W)) i_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (accept),
        .drain_i (advance),
        .data_i  (byte_data_i),
        .held_o  (sh_held),
        .data_o  (sh_data)
    );

    rxq_slot #(.DATA_W(DATA_W)) i_buffer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (advance),
        .drain_i (bf_drain),
        .data_i  (sh_data),
        .held_o  (bf_held),
        .data_o  (bf_data)
    );

    rxq_flags i_flags (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fill_i     (advance),
        .pop_i      (pop_i),
        .buf_held_i (bf_held),
        .clr_i      (flag_clr_i),
        .dv_irq_o   (dv_irq_o),
        .uf_irq_o   (uf_irq_o)
    );

    rxq_read_port #(.DATA_W(DATA_W), .EMPTY_ZERO(1'b1)) i_read (
        .held_i    (bf_held),
        .pop_i     (pop_i),
        .peek_i    (peek_i),
        .data_i    (bf_data),
        .rd_data_o (rd_data_o)
    );

    assign byte_ready_o = ~sh_held;
    assign data_valid_o = bf_held;

endmodule

// File: rtl/rxq_rx_path_chk.sv
module rxq_rx_path_chk
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              byte_valid_i,
    input logic              byte_ready_o,
    input logic              pop_i,
    input logic              peek_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              data_valid_o,
    input logic              dv_irq_o,
    input logic              uf_irq_o,
    input logic [CLR_W-1:0]  flag_clr_i
);

    p_accept_stall_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_valid_i && byte_ready_o |=> !byte_ready_o);

    p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !byte_ready_o && data_valid_o && !pop_i |=> !byte_ready_o);

    p_fill_flag_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(data_valid_o) |-> dv_irq_o);

    p_pop_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_i && data_valid_o |=> !data_valid_o && !dv_irq_o);

    p_underflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_i && !data_valid_o |=> uf_irq_o);

    p_peek_keep_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        peek_i && !pop_i && data_valid_o |=> data_valid_o);

    p_peek_no_uf_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !pop_i && !uf_irq_o |=> !uf_irq_o);

    p_refill_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_i && data_valid_o && !byte_ready_o |=> !data_valid_o ##1 data_valid_o);

    p_uf_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        uf_irq_o && !flag_clr_i[CLR_UF_BIT] |=> uf_irq_o);

    p_empty_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !data_valid_o |-> rd_data_o == '0);

endmodule

bind rxq_rx_path rxq_rx_path_chk #(.DATA_W(DATA_W)) i_rxq_rx_path_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .pop_i        (pop_i),
    .peek_i       (peek_i),
    .rd_data_o    (rd_data_o),
    .data_valid_o (data_valid_o),
    .dv_irq_o     (dv_irq_o),
    .uf_irq_o     (uf_irq_o),
    .flag_clr_i   (flag_clr_i)
);

// File: tb/test_rxq_rx_path.sv
`timescale 1ns/1ps
module test_rxq_rx_path;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          byte_ready;
    logic          pop = 1'b0;
    logic          peek = 1'b0;
    logic [DW-1:0] rd_data;
    logic          data_valid;
    logic          dv_irq;
    logic          uf_irq;
    logic [1:0]    flag_clr = 2'b00;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference model built from the requirements
    logic          m_sh_full, m_buf_full, m_dvirq, m_uf;
    logic [DW-1:0] m_sh, m_buf;
    logic [DW-1:0] order_q[$];

    always #2.5 clk = ~clk;

    rxq_rx_path #(.DATA_W(DW)) i_rxq_rx_path (
        .clk_i        (clk),
        .rst_i        (rst),
        .byte_valid_i (byte_valid),
        .byte_data_i  (byte_data),
        .byte_ready_o (byte_ready),
        .pop_i        (pop),
        .peek_i       (peek),
        .rd_data_o    (rd_data),
        .data_valid_o (data_valid),
        .dv_irq_o     (dv_irq),
        .uf_irq_o     (uf_irq),
        .flag_clr_i   (flag_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic p, input logic k);
        return (m_buf_full && (p || k)) ? m_buf : '0;
    endfunction

    function automatic logic exp_flag(input logic cur, input logic set, input logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    task automatic model_reset();
        m_sh_full = 0; m_buf_full = 0; m_dvirq = 0; m_uf = 0;
        m_sh = '0; m_buf = '0;
        order_q.delete();
    endtask

    // Drive one cycle (called just after a falling edge), check, advance model
    task automatic step(input logic v, input logic [DW-1:0] d, input logic p,
                        input logic k, input logic [1:0] c);
        logic xfer;
        byte_valid = v; byte_data = d; pop = p; peek = k; flag_clr = c;
        #1;
        chk("R2 ready", byte_ready, !m_sh_full);
        chk("R3 data_valid", data_valid, m_buf_full);
        chk("R4 dv_irq", dv_irq, m_dvirq);
        chk("R5 uf_irq", uf_irq, m_uf);
        chk(k && !p ? "R6 peek data" : "R9 read data", rd_data, exp_read(p, k));
        if (p && m_buf_full) begin
            chk("R10 order", rd_data, order_q.pop_front());
        end
        if (v && !m_sh_full) order_q.push_back(d);
        @(posedge clk);
        xfer    = m_sh_full && !m_buf_full;
        m_uf    = exp_flag(m_uf, p && !m_buf_full, c[1]);
        m_dvirq = exp_flag(m_dvirq, xfer, c[0] || (p && m_buf_full));
        if (p && m_buf_full) m_buf_full = 0;
        if (xfer) begin m_buf_full = 1; m_buf = m_sh; m_sh_full = 0; end
        if (v && !m_sh_full && !xfer) begin m_sh_full = 1; m_sh = d; end
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, 2'b00);
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 ready", byte_ready, 1);
        chk("R1 data_valid", data_valid, 0);
        chk("R1 dv_irq", dv_irq, 0);
        chk("R1 uf_irq", uf_irq, 0);

        // R3: handshake then one edge into the buffer
        step(1'b1, 8'hA5, 1'b0, 1'b0, 2'b00);
        chk("R3 not yet valid", data_valid, 0);
        chk("R2 ready low after accept", byte_ready, 0);
        idle();
        chk("R3 valid after move", data_valid, 1);
        chk("R4 dv_irq on fill", dv_irq, 1);

        // R6: peek leaves the byte in place
        step(1'b0, '0, 1'b0, 1'b1, 2'b00);
        chk("R6 still valid", data_valid, 1);
        chk("R6 no underflow", uf_irq, 0);

        // R7: waiting byte refills one cycle after a pop
        step(1'b1, 8'h3C, 1'b0, 1'b0, 2'b00);
        idle();
        chk("R2 stalled while waiting", byte_ready, 0);
        step(1'b0, '0, 1'b1, 1'b0, 2'b00);
        chk("R7 gap cycle", data_valid, 0);
        idle();
        chk("R7 refilled", data_valid, 1);
        chk("R7 dv_irq again", dv_irq, 1);

        // R4: software clear of the data-valid flag keeps the status bit
        step(1'b0, '0, 1'b0, 1'b0, 2'b01);
        chk("R4 dv_irq cleared", dv_irq, 0);
        chk("R4 status kept", data_valid, 1);

        // R5 / R8: underflow and its sticky clear
        step(1'b0, '0, 1'b1, 1'b0, 2'b00);
        step(1'b0, '0, 1'b1, 1'b0, 2'b00);
        chk("R5 underflow set", uf_irq, 1);
        idle();
        chk("R8 underflow sticky", uf_irq, 1);
        step(1'b0, '0, 1'b1, 1'b0, 2'b10);
        chk("R8 set beats clear", uf_irq, 1);
        step(1'b0, '0, 1'b0, 1'b0, 2'b10);
        chk("R8 underflow cleared", uf_irq, 0);

        // Collision: empty pop on the edge the shift byte moves forward
        step(1'b1, 8'h77, 1'b0, 1'b0, 2'b00);
        step(1'b0, '0, 1'b1, 1'b0, 2'b00);
        chk("R5 collision underflow", uf_irq, 1);
        chk("R3 collision fill", data_valid, 1);
        step(1'b0, '0, 1'b1, 1'b0, 2'b10);

        // Random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] c;
            c[0] = ($urandom % 10) == 0;
            c[1] = ($urandom % 10) == 0;
            step(($urandom % 3) != 0, DW'($urandom), ($urandom % 10) < 3,
                 ($urandom % 10) < 3, c);
        end
        // Drain
        for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1, 1'b0, 2'b00);
        chk("R10 all bytes drained", order_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule